// File: doc/BRIEF.md
# Freezable Event Counter Bank

A bank of hardware counters for observing a memory controller. Slot 0 is a 64-bit cycle counter. Slots 1 to 10 are 32-bit counters, and each one counts one strobe chosen by a 7-bit select code. The strobe comes either from a pool of reference events that all slots share or from a group of events private to that slot. Software reaches every control and count value through a simple single-cycle 32-bit register port. A write takes effect on the clock edge it is presented at. A read is combinational from the address.

A global control word can stop the whole bank at once. It also arms the overflow interrupt and the hardware freeze. Each slot has its own control word with a local stop bit, a condition-enable bit and the select code. A counter overflows when an increment turns its top bit from 0 to 1. If the interrupt and the hardware freeze are both armed and the slot has its condition enabled, that same edge sets the global stop bit. The whole bank then holds its values until software reads it and releases it. The interrupt is a level signal. It stays high while any condition-enabled slot has its top bit set and both global enables are on.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset the global word at 0x40 reads 0x8000_0000 (stop-all set, enables clear), every slot control word reads 0, every count reads 0 and `irq_o` is low.
- R2: Slot 0 adds one on every clock edge while its select code is 0 and neither the global stop bit nor its local stop bit is set. A nonzero select code on slot 0 stops it from counting. Slot 0 is 64 bits wide: the low half is at 0x58 and the high half at 0x5C.
- R3: Slot n (1 to 10) adds one on each edge where its selected strobe is high and it is not stopped. Codes 0 to 11 select nothing. Codes 12 to 63 select `ref_evt_i[code]`. Codes 64 to 127 select `spec_evt_i[(n-1)*64 + code-64]`. Its count is at 0x58 + 0x10·n.
- R4: Bit 31 of the slot control word at 0x50 + 0x10·n stops that slot only. Other slots keep counting.
- R5: While bit 31 of the global word is set, no slot advances, whatever its local stop bit says.
- R6: A register write to a count half on the same edge as an increment leaves exactly the written value.
- R7: `irq_o` is high exactly when global bit 30 (interrupt enable) and bit 29 (freeze on condition) are set and some slot with bit 26 (condition enable) set has its top count bit set. It stays high after the stop bit is cleared, and it falls once that top bit is written to 0.
- R8: An increment that turns a condition-enabled slot's top bit from 0 to 1, while bits 30 and 29 are set, sets global bit 31 on that same edge. All slots then hold their values.
- R9: An overflow on a slot with condition enable 0 neither stops the bank nor raises `irq_o`. That slot keeps counting.
- R10: A slot control word reads back stop at bit 31, condition enable at bit 26 and the select code at bits 22:16, with all other bits 0. The word at 0x54 + 0x10·n reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| ref_evt_i | input | 64 | Shared reference event strobes, indexed by select code |
| spec_evt_i | input | 640 | Per-slot private event strobes, 64 per slot 1..10 |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bench checks that the global stop wins over a clear local stop bit; a design with the priority reversed would count during the global stop. It drives a slot up to its top-bit transition with the interrupt armed and checks that the bank stops on that exact edge. If the freeze came one cycle late, the slot would read 0x8000_0001 and slot 0 one cycle more. The 64-bit cycle counter is preset just below its own top bit to prove that the carry crosses the halves and that overflow is detected on bit 63. Further checks cover a write colliding with a count, where a design with the wrong priority would show one too many. They also cover an overflow with condition enable clear, which must not freeze the bank. Random rounds mix all select-code ranges, including the empty codes 0 to 11, together with local stops.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int SEL_W = 7;

  localparam logic [AW-1:0] GBL_OFS   = 8'h40;
  localparam logic [3:0]    BANK_HI   = 4'h5;   // slot 0 starts at 0x50, 16-byte stride
  localparam logic [3:0]    LCA_SUB   = 4'h0;
  localparam logic [3:0]    CNT_SUB   = 4'h8;

  localparam int GBL_FRZ_B = 31;
  localparam int GBL_IE_B  = 30;
  localparam int GBL_CFE_B = 29;
  localparam int LCA_FRZ_B = 31;
  localparam int LCA_CE_B  = 26;
  localparam int LCA_SEL_B = 16;

  typedef struct packed {
    logic             frz;
    logic             cond_en;
    logic [SEL_W-1:0] sel;
  } lcfg_t;
endpackage

// File: rtl/evt_pick.sv
module evt_pick #(
  parameter int SEL_W  = 7,
  parameter int REF_LO = 12,
  localparam int HALF  = 2 ** (SEL_W - 1)
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [HALF-1:0]  ref_i,
  input  logic [HALF-1:0]  spec_i,
  output logic             hit_o
);
  logic [SEL_W-2:0] idx;
  assign idx = sel_i[SEL_W-2:0];

  always_comb begin
    if (sel_i[SEL_W-1])             hit_o = spec_i[idx];
    else if (32'(idx) >= REF_LO)    hit_o = ref_i[idx];
    else                            hit_o = 1'b0;
  end
endmodule

// File: rtl/ctr_unit.sv
module ctr_unit #(
  parameter int W  = 32,
  parameter int DW = 32,
  localparam int LANES = W / DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [LANES-1:0] wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [W-1:0]     cnt_o,
  output logic             msb_o,
  output logic             rise_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (|wr_i) begin
      for (int l = 0; l < LANES; l++)
        if (wr_i[l]) cnt_d[l*DW +: DW] = wdata_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign msb_o  = cnt_q[W-1];
  // overflow only from counting, never from a write
  assign rise_o = ~(|wr_i) & inc_i & ~cnt_q[W-1] & cnt_d[W-1];
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs import evt_ctr_pkg::*; #(
  parameter int N = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gbl_we_i,
  input  logic [2:0]          gbl_wdata_i,   // {frz, ie, cfe}
  input  logic [N-1:0]        lca_we_i,
  input  lcfg_t               lca_wdata_i,
  input  logic                hw_frz_i,
  output logic                frz_all_o,
  output logic                irq_en_o,
  output logic                cfe_o,
  output lcfg_t [N-1:0]       lcfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_all_o <= 1'b1;
      irq_en_o  <= 1'b0;
      cfe_o     <= 1'b0;
    end else begin
      if (gbl_we_i) {frz_all_o, irq_en_o, cfe_o} <= gbl_wdata_i;
      if (hw_frz_i) frz_all_o <= 1'b1;   // hardware freeze wins
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lca
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          lcfg_o[i] <= '0;
      else if (lca_we_i[i]) lcfg_o[i] <= lca_wdata_i;
    end
  end
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank import evt_ctr_pkg::*; #(
  parameter int NUM_CTR = 11,
  parameter int CYC_W   = 64,
  parameter int EVT_W   = 32,
  parameter int REF_LO  = 12,
  localparam int HALF   = 2 ** (SEL_W - 1),
  localparam int SPEC_W = (NUM_CTR - 1) * HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [HALF-1:0]   ref_evt_i,
  input  logic [SPEC_W-1:0] spec_evt_i,
  output logic              irq_o
);
  logic                 frz_all, irq_en, cfe, hw_frz;
  lcfg_t [NUM_CTR-1:0]  lcfg;
  logic [NUM_CTR-1:0]   lfrz, cond_en, hit, inc, msb, rise, lca_we;
  logic [SEL_W-1:0]     sel0;
  logic [CYC_W-1:0]     cyc_cnt;
  logic [NUM_CTR-1:1][EVT_W-1:0] evt_cnt;

  // address decode
  logic [3:0] slot, sub;
  logic       in_bank, gbl_hit, gbl_we;
  assign sub     = reg_addr_i[3:0];
  assign slot    = reg_addr_i[7:4] - BANK_HI;
  assign in_bank = (reg_addr_i[7:4] >= BANK_HI) && (32'(slot) < NUM_CTR);
  assign gbl_hit = (reg_addr_i == GBL_OFS);
  assign gbl_we  = reg_we_i && gbl_hit;

  lcfg_t lca_wdata;
  assign lca_wdata = '{frz:     reg_wdata_i[LCA_FRZ_B],
                       cond_en: reg_wdata_i[LCA_CE_B],
                       sel:     reg_wdata_i[LCA_SEL_B +: SEL_W]};

  ctrl_regs #(.N(NUM_CTR)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gbl_we_i    (gbl_we),
    .gbl_wdata_i ({reg_wdata_i[GBL_FRZ_B], reg_wdata_i[GBL_IE_B], reg_wdata_i[GBL_CFE_B]}),
    .lca_we_i    (lca_we),
    .lca_wdata_i (lca_wdata),
    .hw_frz_i    (hw_frz),
    .frz_all_o   (frz_all),
    .irq_en_o    (irq_en),
    .cfe_o       (cfe),
    .lcfg_o      (lcfg)
  );

  assign sel0 = lcfg[0].sel;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic slot_we;
    assign slot_we   = reg_we_i && in_bank && (slot == 4'(i));
    assign lca_we[i] = slot_we && (sub == LCA_SUB);
    assign lfrz[i]   = lcfg[i].frz;
    assign cond_en[i]= lcfg[i].cond_en;
    assign inc[i]    = ~frz_all & ~lcfg[i].frz & hit[i];

    if (i == 0) begin : g_cyc
      localparam int L = CYC_W / DW;
      logic [L-1:0] wr;
      for (genvar l = 0; l < L; l++) begin : g_lane
        assign wr[l] = slot_we && (sub == CNT_SUB + 4'(4 * l));
      end
      assign hit[0] = (lcfg[0].sel == '0);
      ctr_unit #(.W(CYC_W), .DW(DW)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc[0]), .wr_i(wr),
        .wdata_i(reg_wdata_i), .cnt_o(cyc_cnt), .msb_o(msb[0]), .rise_o(rise[0])
      );
    end else begin : g_evt
      localparam int L = EVT_W / DW;
      logic [L-1:0] wr;
      for (genvar l = 0; l < L; l++) begin : g_lane
        assign wr[l] = slot_we && (sub == CNT_SUB + 4'(4 * l));
      end
      evt_pick #(.SEL_W(SEL_W), .REF_LO(REF_LO)) u_pick (
        .sel_i  (lcfg[i].sel),
        .ref_i  (ref_evt_i),
        .spec_i (spec_evt_i[(i-1)*HALF +: HALF]),
        .hit_o  (hit[i])
      );
      ctr_unit #(.W(EVT_W), .DW(DW)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc[i]), .wr_i(wr),
        .wdata_i(reg_wdata_i), .cnt_o(evt_cnt[i]), .msb_o(msb[i]), .rise_o(rise[i])
      );
    end
  end

  assign hw_frz = irq_en & cfe & |(rise & cond_en);
  assign irq_o  = irq_en & cfe & |(msb & cond_en);

  always_comb begin
    reg_rdata_o = '0;
    if (gbl_hit) begin
      reg_rdata_o[GBL_FRZ_B] = frz_all;
      reg_rdata_o[GBL_IE_B]  = irq_en;
      reg_rdata_o[GBL_CFE_B] = cfe;
    end else if (in_bank) begin
      case (sub)
        LCA_SUB: begin
          reg_rdata_o[LCA_FRZ_B]           = lcfg[slot].frz;
          reg_rdata_o[LCA_CE_B]            = lcfg[slot].cond_en;
          reg_rdata_o[LCA_SEL_B +: SEL_W]  = lcfg[slot].sel;
        end
        CNT_SUB:
          if (slot == 4'd0) reg_rdata_o = cyc_cnt[DW-1:0];
          else              reg_rdata_o = evt_cnt[slot];
        CNT_SUB + 4'd4:
          if (slot == 4'd0) reg_rdata_o = cyc_cnt[2*DW-1:DW];
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk #(
  parameter int N     = 11,
  parameter int CYC_W = 64,
  parameter int EVT_W = 32,
  parameter int SEL_W = 7
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     we_i,
  input logic                     irq_o,
  input logic                     frz_all,
  input logic                     irq_en,
  input logic                     cfe,
  input logic [N-1:0]             lfrz,
  input logic [N-1:0]             cond_en,
  input logic [N-1:0]             msb,
  input logic [SEL_W-1:0]         sel0,
  input logic [CYC_W-1:0]         cyc,
  input logic [N-1:1][EVT_W-1:0]  evt_cnt
);
  AST_GBL_FREEZE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_all && !we_i |=> $stable(cyc) && $stable(evt_cnt)); // R5

  AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frz_all && !lfrz[0] && sel0 == '0 && !we_i |=> cyc == $past(cyc) + 1'b1); // R2

  AST_IRQ_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && frz_all && !we_i |=> irq_o); // R7

  for (genvar k = 1; k < N; k++) begin : g_k
    AST_LOCAL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lfrz[k] && !we_i |=> $stable(evt_cnt[k])); // R4

    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> (evt_cnt[k] == $past(evt_cnt[k])) ||
                (evt_cnt[k] == $past(evt_cnt[k]) + 1'b1)); // R3

    AST_OVF_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(msb[k]) && !$past(we_i) && cond_en[k] && irq_en && cfe |-> frz_all); // R8
  end
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(
  .N(NUM_CTR), .CYC_W(CYC_W), .EVT_W(EVT_W), .SEL_W(evt_ctr_pkg::SEL_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .irq_o(irq_o),
  .frz_all(frz_all), .irq_en(irq_en), .cfe(cfe), .lfrz(lfrz),
  .cond_en(cond_en), .msb(msb), .sel0(sel0), .cyc(cyc_cnt), .evt_cnt(evt_cnt)
);

// File: tb/test_evt_ctr_bank.sv
module test_evt_ctr_bank;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [63:0]  ref_evt = '0;
  logic [639:0] spec_evt = '0;
  logic         irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_ctr_bank i_evt_ctr_bank (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ref_evt_i(ref_evt),
    .spec_evt_i(spec_evt), .irq_o(irq)
  );

  function automatic logic [31:0] gword(bit f, bit ie, bit cfe);
    return {f, ie, cfe, 29'b0};
  endfunction
  function automatic logic [31:0] lword(bit f, bit ce, logic [6:0] sel);
    return {f, 4'b0, ce, 3'b0, sel, 16'b0};
  endfunction
  function automatic logic [7:0] cnt_a(int k);
    return 8'(8'h58 + 16 * k);
  endfunction
  function automatic logic [7:0] lca_a(int k);
    return 8'(8'h50 + 16 * k);
  endfunction
  function automatic bit exp_hit(int k, logic [6:0] code, logic [63:0] r, logic [639:0] s);
    if (code < 12) return 1'b0;
    if (code < 64) return r[code];
    return s[(k-1)*64 + int'(code) - 64];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, v2;

  initial begin
    void'($urandom(32'h5EED_1234));
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h40, v);      chk("R1 global", v, 32'h8000_0000);
    rd(lca_a(4), v);   chk("R1 local", v, 0);
    rd(cnt_a(0), v);   chk("R1 cyc", v, 0);
    rd(cnt_a(7), v);   chk("R1 cnt7", v, 0);
    chk("R1 irq", irq, 0);

    // R10 readback of local fields and the unused word
    wr(lca_a(2), 32'hFFFF_FFFF);
    rd(lca_a(2), v);   chk("R10 lca fields", v, 32'h847F_0000);
    wr(8'h54 + 8'h20, 32'hFFFF_FFFF);
    rd(8'h54 + 8'h20, v); chk("R10 word B", v, 0);
    wr(lca_a(2), 0);

    // R5 global stop overrides clear local stop
    wr(lca_a(1), lword(0, 0, 7'd12));
    ref_evt = '1;
    idle(5);
    rd(cnt_a(1), v);   chk("R5 cnt1 held", v, 0);
    rd(cnt_a(0), v);   chk("R5 cyc held", v, 0);

    // R6 write beats increment
    wr(8'h40, gword(0, 0, 0));
    idle(3);
    wr(cnt_a(1), 32'h1234);
    rd(cnt_a(1), v);   chk("R6 write wins", v, 32'h1234);
    ref_evt = '0;
    wr(8'h40, gword(1, 0, 0));

    // R8 overflow on slot 3 freezes the bank on the same edge
    wr(cnt_a(0), 0);
    wr(lca_a(3), lword(0, 1, 7'd70));
    wr(cnt_a(3), 32'h7FFF_FFFE);
    spec_evt[2*64 + 6] = 1'b1;
    wr(8'h40, gword(0, 1, 1));
    idle(6);
    rd(cnt_a(3), v);   chk("R8 slot3 stopped at msb", v, 32'h8000_0000);
    rd(8'h40, v);      chk("R8 stop bit set", v, 32'hE000_0000);
    rd(cnt_a(0), v);   chk("R8 cyc stopped", v, 2);
    chk("R7 irq high", irq, 1);
    idle(3);
    rd(cnt_a(0), v2);  chk("R8 cyc still held", v2, v);
    spec_evt = '0;
    wr(8'h40, gword(0, 1, 1));
    idle(1);
    chk("R7 irq holds after release", irq, 1);
    wr(cnt_a(3), 0);
    chk("R7 irq drops", irq, 0);
    wr(8'h40, gword(1, 1, 1));

    // R9 overflow without condition enable
    wr(lca_a(5), lword(0, 0, 7'd12));
    wr(cnt_a(5), 32'h7FFF_FFFF);
    wr(cnt_a(1), 0);
    ref_evt[12] = 1'b1;
    wr(8'h40, gword(0, 1, 1));
    idle(4);
    rd(cnt_a(5), v);   chk("R9 keeps counting", v, 32'h8000_0003);
    rd(8'h40, v);      chk("R9 no stop", v, 32'h6000_0000);
    chk("R9 no irq", irq, 0);
    ref_evt = '0;
    wr(8'h40, gword(1, 1, 1));
    wr(lca_a(5), 0);

    // R2 64-bit carry and bit-63 overflow
    wr(lca_a(0), lword(0, 1, 7'd0));
    wr(cnt_a(0), 32'hFFFF_FFFE);
    wr(cnt_a(0) + 8'h4, 32'h7FFF_FFFF);
    wr(8'h40, gword(0, 1, 1));
    idle(5);
    rd(cnt_a(0) + 8'h4, v); chk("R2 cyc high", v, 32'h8000_0000);
    rd(cnt_a(0), v);        chk("R2 cyc low", v, 0);
    rd(8'h40, v);           chk("R8 cyc overflow stops", v, 32'hE000_0000);
    wr(cnt_a(0) + 8'h4, 0);
    chk("R7 irq cleared", irq, 0);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      logic [6:0]  code [11];
      bit          lf [11];
      logic [63:0] expc [11];
      int n;
      wr(8'h40, gword(1, 0, 0));
      for (int k = 0; k < 11; k++) begin
        lf[k]   = ($urandom_range(0, 4) == 0);
        code[k] = (k == 0) ? (($urandom_range(0, 3) == 0) ? 7'd5 : 7'd0)
                           : 7'($urandom_range(0, 127));
        expc[k] = 0;
        wr(lca_a(k), lword(lf[k], 0, code[k]));
        wr(cnt_a(k), 0);
        if (k == 0) wr(cnt_a(0) + 8'h4, 0);
      end
      for (int k = 1; k < 11; k++) begin
        rd(lca_a(k), v);
        chk("R10 random readback", v, lword(lf[k], 0, code[k]));
      end
      wr(8'h40, gword(0, 0, 0));
      n = $urandom_range(20, 60);
      for (int c = 0; c < n; c++) begin
        ref_evt = {$urandom, $urandom};
        for (int j = 0; j < 20; j++) spec_evt[j*32 +: 32] = $urandom;
        for (int k = 1; k < 11; k++)
          if (!lf[k] && exp_hit(k, code[k], ref_evt, spec_evt)) expc[k]++;
        @(negedge clk);
      end
      ref_evt = '0; spec_evt = '0;
      wr(8'h40, gword(1, 0, 0));
      if (!lf[0] && code[0] == 0) expc[0] = 64'(n + 1);
      rd(cnt_a(0), v);
      chk(lf[0] ? "R4 cyc local stop" : "R2 cyc count", v, expc[0]);
      for (int k = 1; k < 11; k++) begin
        rd(cnt_a(k), v);
        chk(lf[k] ? "R4 local stop" : "R3 event count", v, expc[k]);
      end
      chk("R7 irq idle", irq, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule